// File: doc/BRIEF.md
# Two-Mode Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking page tables held in memory. A requester raises `reqValid` with the virtual address and a mode bit while the walker is idle. The walker then reads one table entry per level through a single-outstanding-read memory port. It ends with a one-cycle `done` pulse that carries the physical address and a fault flag. Pages are 4 KB in both modes.

In classic mode the address splits 10/10/12. There are two levels of 4-byte entries, and the output address is 32 bits, zero-extended to 36 bits. In extended mode the address splits 2/9/9/12 and the entries are 8 bytes wide. The top two address bits pick one of four directory base registers, which are loaded through a small write port. The frame number is 24 bits, so the output address is a full 36 bits. Every entry carries a present flag in bit 0. An entry with this flag clear ends the walk with a fault.

Top module: `pageWalker`

## Requirements
- R1: When a walk completes without fault, `paddr[11:0]` equals the low 12 bits of the requested virtual address.
- R2: In classic mode (`reqExt`=0) the first read goes to address `{4'b0, rootBase[31:12], 12'b0} + va[31:22]*4`. The second read goes to `{4'b0, e1[31:12], 12'b0} + va[21:12]*4`, where e1 is the low 32 bits of the first entry. Both reads have `memWide`=0. The low 12 bits of `rootBase` are ignored.
- R3: A classic walk without fault returns `paddr` = `{4'b0, e2[31:12], va[11:0]}`. Bits [63:32] of the response are ignored.
- R4: In extended mode (`reqExt`=1) the directory base is the register with index `va[31:30]`. That register is loaded while `dirWrEn`=1 with `dirWrIdx` as the index and `dirWrData` as the value. The first read goes to that base + `va[29:21]*8`. The second read goes to `{e1[35:12], 12'b0} + va[20:12]*8`. Both reads have `memWide`=1.
- R5: An extended walk without fault returns `paddr` = `{e2[35:12], va[11:0]}`.
- R6: If bit 0 of an entry read at either level is 0, the walk ends after that read. It raises `done` and `fault` together with `paddr` = 0, and it issues no further read.
- R7: `memReq` stays high, with `memAddr` and `memWide` stable, until a cycle in which `memRspValid` is high. Only one read is outstanding at a time, and `memReq` is low once the walk is done.
- R8: `done` is high for exactly one cycle per walk. `fault` is high only while `done` is high.
- R9: A `reqValid` raised while a walk is in progress is ignored. The running walk's reads and result are unchanged.
- R10: While reset is asserted (`rstN`=0), `done`, `fault` and `memReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk (sampled only while idle) |
| reqVaddr | input | 32 | Virtual address to translate |
| reqExt | input | 1 | 0 = classic two-level, 1 = extended three-level |
| rootBase | input | 32 | Classic directory base (bits [31:12] used) |
| dirWrEn | input | 1 | Write strobe for an extended directory base |
| dirWrIdx | input | 2 | Index of the directory base to write |
| dirWrData | input | 36 | Directory base value |
| memReq | output | 1 | Read request, held until response |
| memAddr | output | 36 | Byte address of the entry being read |
| memWide | output | 1 | 1 = 64-bit entry read, 0 = 32-bit |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Read data (low 32 bits used in classic mode) |
| paddr | output | 36 | Translated physical address |
| fault | output | 1 | Walk hit an entry whose present bit is clear |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle the assertions check the handshake and the completion pulse. A pending read must hold its address and width until the response arrives. `done` must last a single cycle, and `fault` may only appear with it. A faulting completion must carry a zero address, and no read may be pending when a walk completes. Only the bench scenarios can show that the addresses computed at each level match the index split of each mode. They also show that the four directory registers are selected correctly and that reserved bits are ignored. Further scenarios cover a missing entry at the first and at the second level, and a request raised mid-walk that is dropped.

// File: rtl/ptwPkg.sv
package ptwPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIR,
    ST_TBL
  } walkState_t;

  typedef struct packed {
    logic capture;      // latch request, pick root base
    logic takeDir;      // first-level entry accepted, latch table base
    logic finishOk;     // second-level entry accepted, publish address
    logic finishFault;  // entry not present, publish fault
  } walkStrobe_t;
endpackage

// File: rtl/ptwCtrl.sv
module ptwCtrl
  import ptwPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRspValid,
  input  logic        entryPresent,
  output walkStrobe_t strobe,
  output logic        memReq,
  output logic        atTable
);
  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    memReq    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          nextState      = ST_DIR;
        end
      end
      ST_DIR: begin
        memReq = 1'b1;
        if (memRspValid) begin
          if (entryPresent) begin
            strobe.takeDir = 1'b1;
            nextState      = ST_TBL;
          end else begin
            strobe.finishFault = 1'b1;
            nextState          = ST_IDLE;
          end
        end
      end
      ST_TBL: begin
        memReq = 1'b1;
        if (memRspValid) begin
          if (entryPresent) strobe.finishOk    = 1'b1;
          else              strobe.finishFault = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign atTable = (state == ST_TBL);
endmodule

// File: rtl/ptwDatapath.sv
module ptwDatapath
  import ptwPkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 36,
  parameter int PAGE_BITS = 12,
  parameter int DIR_COUNT = 4,
  parameter int DATA_W    = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  walkStrobe_t                  strobe,
  input  logic                         atTable,
  input  logic [VA_W-1:0]              reqVaddr,
  input  logic                         reqExt,
  input  logic [VA_W-1:0]              rootBase,
  input  logic                         dirWrEn,
  input  logic [$clog2(DIR_COUNT)-1:0] dirWrIdx,
  input  logic [PA_W-1:0]              dirWrData,
  input  logic [DATA_W-1:0]            memRspData,
  output logic [PA_W-1:0]              memAddr,
  output logic                         memWide,
  output logic                         entryPresent,
  output logic [PA_W-1:0]              paddr,
  output logic                         done,
  output logic                         fault
);
  localparam int SEL_W      = $clog2(DIR_COUNT);
  localparam int CL_IDX_W   = (VA_W - PAGE_BITS) / 2;
  localparam int EX_IDX_W   = (VA_W - PAGE_BITS - SEL_W) / 2;
  localparam int NARROW_W   = 32;
  localparam int CL_SHIFT   = 2;
  localparam int EX_SHIFT   = 3;

  logic [PA_W-1:0] extBase [DIR_COUNT];
  logic [VA_W-1:0] vaReg;
  logic            wideReg;
  logic [PA_W-1:0] topBase;
  logic [PA_W-1:0] tblBase;

  // Directory base registers for the extended mode
  always_ff @(posedge clk) begin
    for (int i = 0; i < DIR_COUNT; i++) begin
      if (!rstN) extBase[i] <= '0;
      else if (dirWrEn && (dirWrIdx == SEL_W'(i))) extBase[i] <= dirWrData;
    end
  end

  // Index fields of the captured address, per mode
  logic [CL_IDX_W-1:0] clDirIdx, clTblIdx;
  logic [EX_IDX_W-1:0] exDirIdx, exTblIdx;
  assign clDirIdx = vaReg[VA_W-1 -: CL_IDX_W];
  assign clTblIdx = vaReg[PAGE_BITS +: CL_IDX_W];
  assign exDirIdx = vaReg[PAGE_BITS + EX_IDX_W +: EX_IDX_W];
  assign exTblIdx = vaReg[PAGE_BITS +: EX_IDX_W];

  logic [PA_W-1:0] levelOffset;
  always_comb begin
    if (wideReg)
      levelOffset = atTable ? (PA_W'(exTblIdx) << EX_SHIFT) : (PA_W'(exDirIdx) << EX_SHIFT);
    else
      levelOffset = atTable ? (PA_W'(clTblIdx) << CL_SHIFT) : (PA_W'(clDirIdx) << CL_SHIFT);
  end

  assign memAddr = (atTable ? tblBase : topBase) + levelOffset;
  assign memWide = wideReg;
  assign entryPresent = memRspData[0];

  // Frame base extracted from the returning entry
  logic [PA_W-1:0] frameBase;
  always_comb begin
    if (wideReg)
      frameBase = PA_W'(memRspData[PA_W-1:PAGE_BITS]) << PAGE_BITS;
    else
      frameBase = PA_W'(memRspData[NARROW_W-1:PAGE_BITS]) << PAGE_BITS;
  end

  logic [PA_W-1:0] rootPick;
  assign rootPick = reqExt ? extBase[reqVaddr[VA_W-1 -: SEL_W]]
                           : (PA_W'(rootBase[VA_W-1:PAGE_BITS]) << PAGE_BITS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg   <= '0;
      wideReg <= 1'b0;
      topBase <= '0;
      tblBase <= '0;
      paddr   <= '0;
      done    <= 1'b0;
      fault   <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (strobe.capture) begin
        vaReg   <= reqVaddr;
        wideReg <= reqExt;
        topBase <= rootPick;
      end
      if (strobe.takeDir) tblBase <= frameBase;
      if (strobe.finishOk) begin
        paddr <= frameBase | PA_W'(vaReg[PAGE_BITS-1:0]);
        done  <= 1'b1;
      end
      if (strobe.finishFault) begin
        paddr <= '0;
        done  <= 1'b1;
        fault <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pageWalker.sv
module pageWalker
  import ptwPkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 36,
  parameter int PAGE_BITS = 12,
  parameter int DIR_COUNT = 4,
  parameter int DATA_W    = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic [VA_W-1:0]              reqVaddr,
  input  logic                         reqExt,
  input  logic [VA_W-1:0]              rootBase,
  input  logic                         dirWrEn,
  input  logic [$clog2(DIR_COUNT)-1:0] dirWrIdx,
  input  logic [PA_W-1:0]              dirWrData,
  output logic                         memReq,
  output logic [PA_W-1:0]              memAddr,
  output logic                         memWide,
  input  logic                         memRspValid,
  input  logic [DATA_W-1:0]            memRspData,
  output logic [PA_W-1:0]              paddr,
  output logic                         fault,
  output logic                         done
);
  walkStrobe_t strobe;
  logic        atTable;
  logic        entryPresent;

  ptwCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .memRspValid  (memRspValid),
    .entryPresent (entryPresent),
    .strobe       (strobe),
    .memReq       (memReq),
    .atTable      (atTable)
  );

  ptwDatapath #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .PAGE_BITS (PAGE_BITS),
    .DIR_COUNT (DIR_COUNT),
    .DATA_W    (DATA_W)
  ) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .atTable      (atTable),
    .reqVaddr     (reqVaddr),
    .reqExt       (reqExt),
    .rootBase     (rootBase),
    .dirWrEn      (dirWrEn),
    .dirWrIdx     (dirWrIdx),
    .dirWrData    (dirWrData),
    .memRspData   (memRspData),
    .memAddr      (memAddr),
    .memWide      (memWide),
    .entryPresent (entryPresent),
    .paddr        (paddr),
    .done         (done),
    .fault        (fault)
  );
endmodule

// File: rtl/ptwChecker.sv
module ptwChecker #(
  parameter int PA_W = 36
) (
  input logic            clk,
  input logic            rstN,
  input logic            memReq,
  input logic            memRspValid,
  input logic [PA_W-1:0] memAddr,
  input logic            memWide,
  input logic [PA_W-1:0] paddr,
  input logic            fault,
  input logic            done
);
  // R7: a pending read keeps its request, address and width
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRspValid) |=> (memReq && $stable(memAddr) && $stable(memWide)));

  // R7: nothing outstanding once the walk has finished
  a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  // R8: completion is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: fault only accompanies done
  a_r8_fault_with_done: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> done);

  // R6: a faulting result carries a zero address
  a_r6_zero_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> (paddr == '0));
endmodule

bind pageWalker ptwChecker #(.PA_W(PA_W)) u_ptwChecker (
  .clk         (clk),
  .rstN        (rstN),
  .memReq      (memReq),
  .memRspValid (memRspValid),
  .memAddr     (memAddr),
  .memWide     (memWide),
  .paddr       (paddr),
  .fault       (fault),
  .done        (done)
);

// File: tb/tb_pageWalker.sv
module tb_pageWalker;
  logic        clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic        reqValid;
  logic [31:0] reqVaddr;
  logic        reqExt;
  logic [31:0] rootBase;
  logic        dirWrEn;
  logic [1:0]  dirWrIdx;
  logic [35:0] dirWrData;
  logic        memReq;
  logic [35:0] memAddr;
  logic        memWide;
  logic        memRspValid;
  logic [63:0] memRspData;
  logic [35:0] paddr;
  logic        fault;
  logic        done;

  pageWalker dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr), .reqExt(reqExt),
    .rootBase(rootBase), .dirWrEn(dirWrEn), .dirWrIdx(dirWrIdx), .dirWrData(dirWrData),
    .memReq(memReq), .memAddr(memAddr), .memWide(memWide), .memRspValid(memRspValid),
    .memRspData(memRspData), .paddr(paddr), .fault(fault), .done(done)
  );

  int checks = 0;
  int errors = 0;
  logic [35:0] absentAddr = 36'h1;
  logic [35:0] extVal [4];
  logic [35:0] logAddr [8];
  logic        logWide [8];
  int          logN = 0;
  int          seedInit = $urandom(32'd4242);

  // Memory contents: a hash of the address; bit 0 is the present flag
  function automatic logic [63:0] memWord(input logic [35:0] a);
    logic [31:0] h1, h2;
    logic [63:0] w;
    h1 = (a[31:0] * 32'h9E3779B1) ^ {a[35:32], 28'h0};
    h2 = (h1 ^ 32'hA5A5_1234) * 32'h85EBCA6B;
    w = {h2, h1};
    w[0] = (a != absentAddr) && (h1[9:6] != 4'd0);
    return w;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory responder: 0..2 cycle latency, one read at a time
  initial begin
    logic [35:0] curAddr;
    logic        pend;
    int          cnt;
    pend = 1'b0; cnt = 0; curAddr = '0;
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      if (memRspValid) begin
        memRspValid = 1'b0;
        memRspData  = {$urandom, $urandom};
        pend        = 1'b0;
      end else if (pend) begin
        if (cnt == 0) begin
          memRspValid = 1'b1;
          memRspData  = memWord(curAddr);
        end else cnt--;
      end else if (memReq && rstN) begin
        curAddr = memAddr;
        if (logN < 8) begin
          logAddr[logN] = memAddr;
          logWide[logN] = memWide;
        end
        logN++;
        pend = 1'b1;
        cnt  = $urandom_range(0, 2);
        if (cnt == 0) begin
          memRspValid = 1'b1;
          memRspData  = memWord(curAddr);
        end else cnt--;
      end
    end
  end

  task automatic expectWalk(input logic [31:0] va, input logic ext,
                            output logic [35:0] a1, output logic [35:0] a2,
                            output logic [35:0] pa, output logic flt, output int nRd);
    logic [63:0] e1, e2;
    logic [35:0] tb;
    if (!ext) a1 = {4'b0, rootBase[31:12], 12'b0} + {24'b0, va[31:22], 2'b00};
    else      a1 = extVal[va[31:30]] + {24'b0, va[29:21], 3'b000};
    e1 = memWord(a1);
    a2 = '0; pa = '0; flt = 1'b0; nRd = 1;
    if (!e1[0]) begin flt = 1'b1; return; end
    tb = ext ? {e1[35:12], 12'b0} : {4'b0, e1[31:12], 12'b0};
    a2 = ext ? tb + {24'b0, va[20:12], 3'b000} : tb + {24'b0, va[21:12], 2'b00};
    e2 = memWord(a2);
    nRd = 2;
    if (!e2[0]) begin flt = 1'b1; return; end
    pa = ext ? {e2[35:12], va[11:0]} : {4'b0, e2[31:12], va[11:0]};
  endtask

  task automatic runWalk(input logic [31:0] va, input logic ext, input logic inject);
    logic [35:0] a1, a2, pa;
    logic        flt;
    int          nRd, waitCnt;
    string       mTag, rTag;
    expectWalk(va, ext, a1, a2, pa, flt, nRd);
    mTag = ext ? "R4" : "R2";
    rTag = ext ? "R5" : "R3";
    logN = 0;
    @(negedge clk);
    reqVaddr = va; reqExt = ext; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (inject) begin
      reqVaddr = ~va; reqExt = ~ext; reqValid = 1'b1;   // R9: must be ignored
      @(negedge clk);
      reqValid = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 60) begin
      @(negedge clk);
      waitCnt++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8 timeout actual=0 expected=1");
      return;
    end
    chk(inject ? "R9 fault" : (flt ? "R6 fault" : "R6 nofault"), {63'b0, fault}, {63'b0, flt});
    chk(inject ? "R9 paddr" : (flt ? "R6 paddr" : rTag), {28'b0, paddr}, {28'b0, pa});
    if (!flt) chk("R1 offset", {52'b0, paddr[11:0]}, {52'b0, va[11:0]});
    chk(flt ? "R6 read count" : "R7 read count", logN, nRd);
    chk({mTag, " dir addr"}, {28'b0, logAddr[0]}, {28'b0, a1});
    chk({mTag, " width"}, {63'b0, logWide[0]}, {63'b0, ext});
    if (nRd == 2) chk({mTag, " tbl addr"}, {28'b0, logAddr[1]}, {28'b0, a2});
    chk("R7 no req at done", {63'b0, memReq}, 64'd0);
    @(negedge clk);
    chk("R8 pulse", {62'b0, done, fault}, 64'd0);
  endtask

  task automatic writeDir(input int idx, input logic [35:0] val);
    @(negedge clk);
    dirWrEn = 1'b1; dirWrIdx = 2'(idx); dirWrData = val;
    extVal[idx] = val;
    @(negedge clk);
    dirWrEn = 1'b0;
  endtask

  // Global watchdog
  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [35:0] a1, a2, pa;
    logic        flt;
    int          nRd;
    rstN = 1'b0; reqValid = 1'b0; reqVaddr = '0; reqExt = 1'b0;
    rootBase = 32'h1234_5ABC; dirWrEn = 1'b0; dirWrIdx = '0; dirWrData = '0;
    for (int i = 0; i < 4; i++) extVal[i] = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset done", {63'b0, done}, 64'd0);
    chk("R10 reset fault", {63'b0, fault}, 64'd0);
    chk("R10 reset memReq", {63'b0, memReq}, 64'd0);
    rstN = 1'b1;

    writeDir(0, 36'h1_0000_0000);
    writeDir(1, 36'h2_3456_7000);
    writeDir(2, 36'h9_ABCD_E020);
    writeDir(3, 36'hF_FFFF_F000);

    // Classic corners, root base with junk in its low 12 bits (R2)
    runWalk(32'h0000_0000, 1'b0, 1'b0);
    runWalk(32'hFFFF_FFFF, 1'b0, 1'b0);
    runWalk(32'h8040_1ABC, 1'b0, 1'b0);
    // Extended: every directory register (R4)
    for (int d = 0; d < 4; d++) runWalk({2'(d), 30'h2AB5_5123}, 1'b1, 1'b0);
    runWalk(32'h3FFF_FFFF, 1'b1, 1'b0);

    // R6: absent at first level, both modes
    expectWalk(32'h1357_9BDF, 1'b0, a1, a2, pa, flt, nRd);
    absentAddr = a1;
    runWalk(32'h1357_9BDF, 1'b0, 1'b0);
    expectWalk(32'hC246_8ACE, 1'b1, a1, a2, pa, flt, nRd);
    absentAddr = a1;
    runWalk(32'hC246_8ACE, 1'b1, 1'b0);
    // R6: absent at second level, both modes
    absentAddr = 36'h1;
    expectWalk(32'h0F0F_0F0F, 1'b0, a1, a2, pa, flt, nRd);
    if (nRd == 2) absentAddr = a2;
    runWalk(32'h0F0F_0F0F, 1'b0, 1'b0);
    absentAddr = 36'h1;
    expectWalk(32'h7070_7070, 1'b1, a1, a2, pa, flt, nRd);
    if (nRd == 2) absentAddr = a2;
    runWalk(32'h7070_7070, 1'b1, 1'b0);
    absentAddr = 36'h1;

    // R9: request during a walk is ignored
    runWalk(32'h4444_5678, 1'b0, 1'b1);
    runWalk(32'hB0B0_C0DE, 1'b1, 1'b1);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      if (n % 50 == 0) rootBase = $urandom;
      runWalk($urandom, 1'($urandom), ($urandom_range(0, 7) == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule